// File: doc/BRIEF.md
# Serial Lane Receive Bring-Up Sequencer

This block walks the receive half of a high-speed serial lane from power-up to a usable state. It runs on a free-running stable clock and drives three control outputs: the PLL reset, the lane receive reset and a receive user-ready strobe. After each control step it waits for the matching status input: PLL lock, a stable recovered clock, reset completion, phase-alignment completion when that stage is used, and data-valid. It raises `done_o` only after data-valid has stayed high for a settle interval.

Each wait has a timeout derived from the clock period. When a timeout expires, the block goes back to the PLL reset step and counts the retry in a saturating counter. A lost reference clock, or loss of data-valid after `done_o` is high, also sends it back to the reset step, but no retry is counted. Every status input passes through a two-stage synchronizer before the state machine uses it. The data path itself, the PLL and the phase aligner are outside the block. Only their handshakes reach it, as plain level signals.

Top module: `rx_bringup_seq`

## Requirements
- R1: While `rst_i` is high (synchronous, active high), `pll_reset_o` and `lane_reset_o` are 1, and `user_ready_o`, `run_phalign_o`, `done_o` and `retry_count_o` are 0.
- R2: After reset the outputs change in a fixed order: `pll_reset_o` falls, then `lane_reset_o` falls (once PLL lock is seen), then `user_ready_o` rises, then `run_phalign_o` rises, then `done_o` rises. `pll_reset_o` is never high while `lane_reset_o` is low.
- R3: `user_ready_o` rises only after `tx_ready_i` has been seen high. While `tx_ready_i` stays low, `user_ready_o` stays 0 even when the recovered clock is stable.
- R4: With `HAS_CLK_MON`=0, the recovered clock counts as stable after `CDR_LOCK_CYCLES` cycles with the lane reset released. The stable flag then holds until the lane reset is asserted again. `user_ready_o` therefore rises no earlier than `CDR_LOCK_CYCLES` cycles after `lane_reset_o` falls.
- R5: With `USE_PHALIGN`=0, `run_phalign_o` stays 0 and `phalign_done_i` is ignored. `done_o` can rise while `phalign_done_i` is low.
- R6: When the block is waiting for data-valid, `done_o` rises exactly DONE_CYC+3 clock edges after `data_valid_i` rises. DONE_CYC is ceil(`DONE_DELAY_NS`/`CLK_PERIOD_NS`). The three extra edges are two synchronizer stages and one state transition.
- R7: If `data_valid_i` drops during the settle interval, `done_o` stays 0 and the settle interval starts again on the next rise.
- R8: If PLL lock, clock stability, transmit-ready, reset-done or phase-alignment-done is still missing after ceil(`STEP_TIMEOUT_NS`/`CLK_PERIOD_NS`) cycles in its state, `pll_reset_o` reasserts and `retry_count_o` increments by one. Back-to-back lock timeouts are `PLL_RST_CYCLES`+STEP_CYC edges apart.
- R9: `retry_count_o` saturates at 2^`RETRY_W`-1 and is cleared only by `rst_i`.
- R10: While `refclk_lost_i` is high, the block returns to the PLL reset step. `done_o` clears and `retry_count_o` does not change.
- R11: If `data_valid_i` falls while `done_o` is high, `done_o` clears and `lane_reset_o` reasserts within 3 edges, and `retry_count_o` does not change.
- R12: If data-valid is not seen within ceil(`DV_WAIT_NS`/`CLK_PERIOD_NS`) cycles of entering its wait, the block retries as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stable free-running clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pll_lock_i | input | 1 | PLL lock status (asynchronous) |
| refclk_lost_i | input | 1 | PLL reference clock lost (asynchronous) |
| recclk_stable_i | input | 1 | Recovered clock stable from an external monitor; used only when `HAS_CLK_MON`=1 |
| reset_done_i | input | 1 | Lane receive reset completed |
| phalign_done_i | input | 1 | Phase alignment completed |
| data_valid_i | input | 1 | Received data aligned and valid |
| tx_ready_i | input | 1 | Transmit-side user-ready; tie high when the receive user clock does not come from the transmit clock |
| pll_reset_o | output | 1 | PLL reset |
| lane_reset_o | output | 1 | Lane receive reset |
| user_ready_o | output | 1 | Receive user clock is usable |
| run_phalign_o | output | 1 | Request phase alignment |
| done_o | output | 1 | Receive side up |
| retry_count_o | output | RETRY_W | Saturating count of timeouts |

## Verification
The hardest states to reach are the saturated retry counter and the data-valid timeout, because both need the lane model to withhold a handshake for thousands of cycles. The bench blocks the modelled PLL lock so that the lock wait expires again and again. It also lowers data-valid after one bring-up so that the block sits in the data-valid wait until that wait expires. A restart during the settle interval is reached by pulsing data-valid for less than the settle time before the final rise. That final rise is then timed edge by edge.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  typedef enum logic [3:0] {
    ST_PLL_RST,
    ST_WAIT_LOCK,
    ST_WAIT_CLK,
    ST_WAIT_TXRDY,
    ST_WAIT_RSTDONE,
    ST_PHALIGN,
    ST_WAIT_DV,
    ST_SETTLE,
    ST_DONE
  } rxseq_state_e;

  // Round a duration in ns up to whole clock cycles (at least one).
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/rxseq_sync.sv
module rxseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= '0;
      else       chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rxseq_timer.sv
module rxseq_timer #(
  parameter int           W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)             cnt_q <= INIT;
    else if (load_i)       cnt_q <= value_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // An expired timer stays expired until the state machine reloads it (R8).
  assert_timer_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/rxseq_clk_stable.sv
module rxseq_clk_stable #(
  parameter bit HAS_CLK_MON     = 1'b0,
  parameter int CDR_LOCK_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lane_rst_i,
  input  logic mon_stable_i,
  output logic stable_o
);

  logic stable_q;

  if (HAS_CLK_MON) begin : g_monitor
    always_ff @(posedge clk_i) begin
      if (rst_i || lane_rst_i) stable_q <= 1'b0;
      else                     stable_q <= mon_stable_i;
    end
  end else begin : g_counter
    localparam int CW = $clog2(CDR_LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CDR_LOCK_CYCLES - 1);
    logic [CW-1:0] cnt_q;
    logic          unused_mon;
    assign unused_mon = mon_stable_i;

    always_ff @(posedge clk_i) begin
      if (rst_i || lane_rst_i) begin
        cnt_q    <= '0;
        stable_q <= 1'b0;
      end else if (!stable_q) begin
        if (cnt_q == LAST) stable_q <= 1'b1;
        else               cnt_q    <= cnt_q + 1'b1;
      end
    end

    // Once stable, the flag holds until the lane reset returns (R4).
    assert_stable_latch_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (stable_q && !lane_rst_i) |=> stable_q);
  end

  assign stable_o = stable_q;

endmodule

// File: rtl/rx_bringup_seq.sv
module rx_bringup_seq
  import rxseq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS   = 8,
  parameter int unsigned STEP_TIMEOUT_NS = 50000,
  parameter int unsigned DV_WAIT_NS      = 100000,
  parameter int unsigned DONE_DELAY_NS   = 1000,
  parameter int unsigned CDR_LOCK_CYCLES = 2000,
  parameter int unsigned PLL_RST_CYCLES  = 8,
  parameter int          RETRY_W         = 8,
  parameter bit          HAS_CLK_MON     = 1'b0,
  parameter bit          USE_PHALIGN     = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               pll_lock_i,
  input  logic               refclk_lost_i,
  input  logic               recclk_stable_i,
  input  logic               reset_done_i,
  input  logic               phalign_done_i,
  input  logic               data_valid_i,
  input  logic               tx_ready_i,
  output logic               pll_reset_o,
  output logic               lane_reset_o,
  output logic               user_ready_o,
  output logic               run_phalign_o,
  output logic               done_o,
  output logic [RETRY_W-1:0] retry_count_o
);

  localparam int unsigned STEP_CYC = ns_to_cycles(STEP_TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int unsigned DV_CYC   = ns_to_cycles(DV_WAIT_NS, CLK_PERIOD_NS);
  localparam int unsigned DONE_CYC = ns_to_cycles(DONE_DELAY_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC  =
    (DV_CYC > STEP_CYC) ? ((DV_CYC > DONE_CYC) ? DV_CYC : DONE_CYC)
                        : ((STEP_CYC > DONE_CYC) ? STEP_CYC : DONE_CYC);
  localparam int unsigned TOP_CYC  = (MAX_CYC > PLL_RST_CYCLES) ? MAX_CYC : PLL_RST_CYCLES;
  localparam int TMR_W = $clog2(TOP_CYC + 1);
  localparam logic [TMR_W-1:0] LD_PLL  = TMR_W'(PLL_RST_CYCLES - 1);
  localparam logic [TMR_W-1:0] LD_STEP = TMR_W'(STEP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_DV   = TMR_W'(DV_CYC - 1);
  localparam logic [TMR_W-1:0] LD_DONE = TMR_W'(DONE_CYC - 1);
  localparam logic [RETRY_W-1:0] RETRY_MAX = '1;
  localparam int NSYNC = 7;

  // Synchronized status inputs
  logic [NSYNC-1:0] raw_in, syn_q;
  logic lock_s, lost_s, mon_s, rd_s, ph_s, dv_s, tx_s;

  assign raw_in = {tx_ready_i, data_valid_i, phalign_done_i, reset_done_i,
                   recclk_stable_i, refclk_lost_i, pll_lock_i};
  assign {tx_s, dv_s, ph_s, rd_s, mon_s, lost_s, lock_s} = syn_q;

  rxseq_sync #(.WIDTH(NSYNC), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_in),
    .q_o   (syn_q)
  );

  rxseq_state_e state_q, state_d;
  logic         timeout;
  logic         clk_ok;
  logic         ph_ok;
  logic         tmr_zero, tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic [RETRY_W-1:0] retry_q;

  rxseq_clk_stable #(.HAS_CLK_MON(HAS_CLK_MON), .CDR_LOCK_CYCLES(CDR_LOCK_CYCLES)) u_clk_stable (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .lane_rst_i   (lane_reset_o),
    .mon_stable_i (mon_s),
    .stable_o     (clk_ok)
  );

  rxseq_timer #(.W(TMR_W), .INIT(LD_PLL)) u_timer (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (tmr_load),
    .value_i (tmr_val),
    .zero_o  (tmr_zero)
  );

  assign ph_ok = USE_PHALIGN ? ph_s : 1'b1;

  // Next-state selection
  always_comb begin
    state_d = state_q;
    timeout = 1'b0;
    unique case (state_q)
      ST_PLL_RST:      if (!lost_s && tmr_zero) state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK:    if (lock_s) state_d = ST_WAIT_CLK;
                       else if (tmr_zero) timeout = 1'b1;
      ST_WAIT_CLK:     if (clk_ok) state_d = ST_WAIT_TXRDY;
                       else if (tmr_zero) timeout = 1'b1;
      ST_WAIT_TXRDY:   if (tx_s) state_d = ST_WAIT_RSTDONE;
                       else if (tmr_zero) timeout = 1'b1;
      ST_WAIT_RSTDONE: if (rd_s) state_d = USE_PHALIGN ? ST_PHALIGN : ST_WAIT_DV;
                       else if (tmr_zero) timeout = 1'b1;
      ST_PHALIGN:      if (ph_ok) state_d = ST_WAIT_DV;
                       else if (tmr_zero) timeout = 1'b1;
      ST_WAIT_DV:      if (dv_s) state_d = ST_SETTLE;
                       else if (tmr_zero) timeout = 1'b1;
      ST_SETTLE:       if (!dv_s) state_d = ST_WAIT_DV;
                       else if (tmr_zero) state_d = ST_DONE;
      ST_DONE:         if (!dv_s) state_d = ST_PLL_RST;
      default:         state_d = ST_PLL_RST;
    endcase
    if (timeout) state_d = ST_PLL_RST;
    if (lost_s && state_q != ST_PLL_RST) state_d = ST_PLL_RST;
  end

  // Timer reload on every state entry
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_PLL_RST: tmr_val = LD_PLL;
      ST_WAIT_DV: tmr_val = LD_DV;
      ST_SETTLE:  tmr_val = LD_DONE;
      default:    tmr_val = LD_STEP;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_PLL_RST;
      retry_q <= '0;
    end else begin
      state_q <= state_d;
      if (timeout && retry_q != RETRY_MAX) retry_q <= retry_q + 1'b1;
    end
  end

  // Outputs decoded from the registered state
  always_comb begin
    pll_reset_o   = (state_q == ST_PLL_RST);
    lane_reset_o  = (state_q == ST_PLL_RST) || (state_q == ST_WAIT_LOCK);
    user_ready_o  = (state_q == ST_WAIT_RSTDONE) || (state_q == ST_PHALIGN) ||
                    (state_q == ST_WAIT_DV) || (state_q == ST_SETTLE) ||
                    (state_q == ST_DONE);
    run_phalign_o = USE_PHALIGN && (state_q == ST_PHALIGN);
    done_o        = (state_q == ST_DONE);
  end

  assign retry_count_o = retry_q;

  // ---------------- assertions ----------------
  assert_reset_nesting_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    pll_reset_o |-> lane_reset_o);

  assert_urdy_after_tx_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(user_ready_o) |-> $past(tx_s));

  assert_done_from_settle_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(done_o) |-> $past(state_q) == ST_SETTLE);

  assert_retry_step_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (retry_q == $past(retry_q)) || (retry_q == $past(retry_q) + 1'b1));

  assert_retry_sat_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (retry_q == RETRY_MAX) |=> (retry_q == RETRY_MAX));

  assert_lost_clears_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    lost_s |=> !done_o);

  assert_dv_drop_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && !dv_s) |=> (!done_o && lane_reset_o));

endmodule

// File: tb/rx_bringup_seq_tb_top.sv
module rx_bringup_seq_tb_top;

  localparam int PER      = 10;
  localparam int STEP_CYC = 2000;
  localparam int DV_CYC   = 10000;
  localparam int DONE_CYC = 100;
  localparam int CDR      = 500;
  localparam int PLLR     = 8;
  localparam int RW       = 2;
  localparam int LOCK_DLY = 20;
  localparam int RD_DLY   = 30;
  localparam int PH_DLY   = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_lock = 1'b0, refclk_lost = 1'b0, reset_done = 1'b0, phalign_done = 1'b0;
  logic data_valid = 1'b1, tx_ready = 1'b1, lock_block = 1'b0;

  logic pll_reset, lane_reset, user_ready, run_phalign, done;
  logic [RW-1:0] retry;
  logic b_pll_reset, b_lane_reset, b_user_ready, b_run_phalign, b_done;
  logic [RW-1:0] b_retry;

  always #(PER/2) clk = ~clk;

  rx_bringup_seq #(
    .CLK_PERIOD_NS(PER), .STEP_TIMEOUT_NS(STEP_CYC*PER), .DV_WAIT_NS(DV_CYC*PER),
    .DONE_DELAY_NS(DONE_CYC*PER), .CDR_LOCK_CYCLES(CDR), .PLL_RST_CYCLES(PLLR),
    .RETRY_W(RW), .HAS_CLK_MON(1'b0), .USE_PHALIGN(1'b1)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .pll_lock_i(pll_lock), .refclk_lost_i(refclk_lost),
    .recclk_stable_i(1'b0), .reset_done_i(reset_done), .phalign_done_i(phalign_done),
    .data_valid_i(data_valid), .tx_ready_i(tx_ready), .pll_reset_o(pll_reset),
    .lane_reset_o(lane_reset), .user_ready_o(user_ready), .run_phalign_o(run_phalign),
    .done_o(done), .retry_count_o(retry)
  );

  // Same stimulus, phase alignment bypassed (R5)
  rx_bringup_seq #(
    .CLK_PERIOD_NS(PER), .STEP_TIMEOUT_NS(STEP_CYC*PER), .DV_WAIT_NS(DV_CYC*PER),
    .DONE_DELAY_NS(DONE_CYC*PER), .CDR_LOCK_CYCLES(CDR), .PLL_RST_CYCLES(PLLR),
    .RETRY_W(RW), .HAS_CLK_MON(1'b0), .USE_PHALIGN(1'b0)
  ) dut_b (
    .clk_i(clk), .rst_i(rst), .pll_lock_i(pll_lock), .refclk_lost_i(refclk_lost),
    .recclk_stable_i(1'b0), .reset_done_i(reset_done), .phalign_done_i(phalign_done),
    .data_valid_i(data_valid), .tx_ready_i(tx_ready), .pll_reset_o(b_pll_reset),
    .lane_reset_o(b_lane_reset), .user_ready_o(b_user_ready), .run_phalign_o(b_run_phalign),
    .done_o(b_done), .retry_count_o(b_retry)
  );

  // ---------------- lane model with programmable delays ----------------
  int lock_cnt = 0, rd_cnt = 0, ph_cnt = 0;
  always @(posedge clk) begin
    if (pll_reset) begin lock_cnt <= 0; pll_lock <= 1'b0; end
    else if (!lock_block) begin
      if (lock_cnt >= LOCK_DLY) pll_lock <= 1'b1; else lock_cnt <= lock_cnt + 1;
    end
    if (lane_reset) begin rd_cnt <= 0; reset_done <= 1'b0; ph_cnt <= 0; phalign_done <= 1'b0; end
    else begin
      if (user_ready) begin
        if (rd_cnt >= RD_DLY) reset_done <= 1'b1; else rd_cnt <= rd_cnt + 1;
      end
      if (run_phalign) begin
        if (ph_cnt >= PH_DLY) phalign_done <= 1'b1; else ph_cnt <= ph_cnt + 1;
      end
    end
  end

  // ---------------- checking ----------------
  int total = 0, bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard: 0 pll release, 1 lane release, 2 user ready, 3 phase align, 4 done
  int exp_q[$];
  bit sb_on = 1'b0;
  task automatic note_event(input int ev);
    int e;
    if (!sb_on) return;
    if (exp_q.size() == 0) chk("R2 unexpected event", 1'b0, ev, -1);
    else begin
      e = exp_q.pop_front();
      chk("R2 event order", e == ev, ev, e);
    end
  endtask

  logic p_pll = 1'b1, p_lane = 1'b1, p_urdy = 1'b0, p_pha = 1'b0, p_done = 1'b0;
  logic p_bdone = 1'b0, p_phd = 1'b0;
  longint lane_fall_cyc = 0, urdy_cyc = 0, ph_rise_cyc = 0;
  bit b_pha_seen = 1'b0, b_done_early = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_pll && !pll_reset) note_event(0);
      if (p_lane && !lane_reset) begin note_event(1); lane_fall_cyc = cyc; end
      if (!p_urdy && user_ready) begin note_event(2); urdy_cyc = cyc; end
      if (!p_pha && run_phalign) note_event(3);
      if (!p_done && done) note_event(4);
      if (!p_phd && phalign_done) ph_rise_cyc = cyc;
      if (b_run_phalign) b_pha_seen = 1'b1;
      if (!p_bdone && b_done && !phalign_done) b_done_early = 1'b1;
    end
    p_pll = pll_reset; p_lane = lane_reset; p_urdy = user_ready; p_pha = run_phalign;
    p_done = done; p_bdone = b_done; p_phd = phalign_done;
  end

  task automatic wait_done(input int maxc);
    for (int i = 0; i < maxc && !done; i++) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic wait_retry(input int val, input int maxc);
    for (int i = 0; i < maxc && retry != RW'(val); i++) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic wait_phdone(input int maxc);
    for (int i = 0; i < maxc && !phalign_done; i++) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic wait_lane_low(input int maxc);
    for (int i = 0; i < maxc && lane_reset; i++) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint t0;
    int n;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 pll_reset", pll_reset == 1'b1, pll_reset, 1);
    chk("R1 lane_reset", lane_reset == 1'b1, lane_reset, 1);
    chk("R1 quiet outputs", {user_ready, run_phalign, done} == 3'b000, {user_ready, run_phalign, done}, 0);
    chk("R1 retry", retry == '0, retry, 0);

    // R2 full bring-up, scoreboard ordering
    exp_q = '{0, 1, 2, 3, 4};
    sb_on = 1'b1;
    rst = 1'b0;
    wait_done(5000);
    step(1);
    sb_on = 1'b0;
    chk("R2 done reached", done == 1'b1, done, 1);
    chk("R2 all events seen", exp_q.size() == 0, exp_q.size(), 0);
    chk("R4 clock stable wait min", (urdy_cyc - lane_fall_cyc) >= CDR, urdy_cyc - lane_fall_cyc, CDR);
    chk("R4 clock stable wait max", (urdy_cyc - lane_fall_cyc) <= CDR + 10, urdy_cyc - lane_fall_cyc, CDR + 10);
    chk("R5 bypass never runs phase align", b_pha_seen == 1'b0, b_pha_seen, 0);
    chk("R5 bypass done without phase done", b_done_early == 1'b1, b_done_early, 1);

    // R11 data-valid loss after done
    data_valid = 1'b0;
    step(4);
    chk("R11 done cleared", done == 1'b0, done, 0);
    chk("R11 lane reset back", lane_reset == 1'b1, lane_reset, 1);
    chk("R11 retry unchanged", retry == '0, retry, 0);

    // R7 then R6: settle restart and exact done delay
    step(4);
    wait_phdone(4000);
    step(10);
    data_valid = 1'b1;
    step(30);
    data_valid = 1'b0;
    step(10);
    chk("R7 no done after short valid", done == 1'b0, done, 0);
    data_valid = 1'b1;
    n = 0;
    while (!done && n < 500) begin @(posedge clk); n++; @(negedge clk); end
    chk("R6 done delay edges", n == DONE_CYC + 3, n, DONE_CYC + 3);

    // R10 reference clock loss
    refclk_lost = 1'b1;
    step(4);
    chk("R10 done cleared", done == 1'b0, done, 0);
    chk("R10 pll reset back", pll_reset == 1'b1, pll_reset, 1);
    chk("R10 retry unchanged", retry == '0, retry, 0);
    refclk_lost = 1'b0;
    wait_done(5000);
    chk("R10 recovers", done == 1'b1, done, 1);

    // R12 data-valid timeout
    data_valid = 1'b0;
    step(4);
    wait_retry(1, 16000);
    chk("R12 retry after dv timeout", retry == RW'(1), retry, 1);
    chk("R12 pll reset on timeout", pll_reset == 1'b1, pll_reset, 1);
    chk("R12 wait length", (cyc - ph_rise_cyc) >= DV_CYC && (cyc - ph_rise_cyc) <= DV_CYC + 10,
        cyc - ph_rise_cyc, DV_CYC + 3);

    // R8 / R9 lock timeouts
    lock_block = 1'b1;
    wait_retry(2, 3000);
    chk("R8 retry increments", retry == RW'(2), retry, 2);
    chk("R8 pll reset on timeout", pll_reset == 1'b1, pll_reset, 1);
    t0 = cyc;
    wait_retry(3, 3000);
    chk("R8 timeout spacing", (cyc - t0) == PLLR + STEP_CYC, cyc - t0, PLLR + STEP_CYC);
    step(2100);
    chk("R9 retry saturates", retry == RW'(3), retry, 3);

    // R3 transmit-ready gating
    tx_ready = 1'b0;
    data_valid = 1'b1;
    lock_block = 1'b0;
    wait_lane_low(3000);
    step(CDR + 100);
    chk("R3 user ready held by tx", user_ready == 1'b0, user_ready, 0);
    tx_ready = 1'b1;
    step(6);
    chk("R3 user ready after tx", user_ready == 1'b1, user_ready, 1);
    wait_done(5000);
    chk("R2 final bring-up", done == 1'b1, done, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule